// File: doc/BRIEF.md
# Display RAM Page/Column Address Generator

This block produces the host-side address into a graphic display RAM arranged as eight data pages of eight rows each, plus a single indicator page, with 102 columns per page. The host loads a page register and a column register with command strobes. It then streams display bytes through the block, and every byte goes to the current page and column. After each byte read or write the block moves to the next column on its own. When a page is finished, it carries into the next page.

The walk through the RAM wraps in a fixed way. Only the eight data pages are visited automatically, and the walk returns to page 0, column 0 after the last column of page 7. The indicator page is reached only by loading it directly. While the indicator page is selected, the column wraps and the page stays where it is. A mirror option maps a column to a segment driver number in either normal or reversed order, so a panel can be mounted either way round. Each host byte is stored as one column slice of a page, with bit 0 as the top row of that page. The RAM is external to the block, and the block passes the write byte through to it.

Top module: `disp_addr_gen`

## Requirements
- R1: After reset the page register and the column register both read 0 and the segment mapping is normal. Reset does not clear RAM contents.
- R2: A page-load strobe with a value from 0 to 8 sets the page from the next cycle. A value from 9 to 15 is ignored, and the page keeps its previous value.
- R3: A column-load strobe with a value from 0 to 101 sets the column from the next cycle. A value from 102 to 127 is ignored, and the column keeps its previous value.
- R4: Each access strobe, whether read or write, advances the column by one when the column is below 101. The page is left unchanged.
- R5: An access at column 101 on pages 0 to 6 sets the column to 0 and advances the page by one.
- R6: An access at column 101 on page 7 sets both the column and the page to 0.
- R7: An access at column 101 on page 8 sets the column to 0 and leaves the page at 8. The page never advances to 8 on its own.
- R8: During an access the RAM address is page*102 + column, taken from the registers before that access. The write enable is high only for a write access, and the write byte is passed through unchanged. A read asserts no write enable.
- R9: With the mirror option off, the segment index equals the current column. With it on, the segment index equals 101 minus the column. The option is set by its own strobe and takes effect from the next cycle.
- R10: When a load strobe and an access arrive in the same cycle, the access uses the old address, and the loaded value replaces the advanced value for that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| page_ld | input | 1 | Page-load strobe |
| page_val | input | 4 | Page value to load |
| col_ld | input | 1 | Column-load strobe |
| col_val | input | 7 | Column value to load |
| mirror_ld | input | 1 | Mirror-option load strobe |
| mirror_val | input | 1 | Mirror option: 1 = reversed segment order |
| acc | input | 1 | Display-data access strobe |
| acc_wr | input | 1 | Access is a write (1) or read (0) |
| host_wdata | input | 8 | Write byte from the host |
| ram_addr | output | 10 | RAM word address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write byte |
| cur_page | output | 4 | Current page register |
| cur_col | output | 7 | Current column register |
| cur_seg | output | 7 | Segment index driven by the current column |

## Verification
The bench targets the three ways the column can wrap. A design that carried into page 8 after page 7, or that moved forward from page 8, would send bytes to the indicator page or to an address beyond it. It would show up as a wrong page and as read data that does not match. Out-of-range page and column loads are exercised, because a design that latched them would produce an address outside the array. The bench also issues loads in the same cycle as accesses, which exposes a design that lets the advance win, or that uses the new address for the current byte. Mirror mode is checked at both ends of the column range, where an off-by-one mapping gives segment 102 or segment 100.

// File: rtl/disp_addr_gen.sv
module disp_addr_gen #(
  parameter int COLS = 102,
  parameter int DATA_PAGES = 8,
  localparam int COL_W = $clog2(COLS),
  localparam int PAGE_W = $clog2(DATA_PAGES + 1),
  localparam int ADDR_W = $clog2((DATA_PAGES + 1) * COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_ld,
  input  logic [PAGE_W-1:0] page_val,
  input  logic              col_ld,
  input  logic [COL_W-1:0]  col_val,
  input  logic              mirror_ld,
  input  logic              mirror_val,
  input  logic              acc,
  input  logic              acc_wr,
  input  logic [7:0]        host_wdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_we,
  output logic [7:0]        ram_wdata,
  output logic [PAGE_W-1:0] cur_page,
  output logic [COL_W-1:0]  cur_col,
  output logic [COL_W-1:0]  cur_seg
);

  localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(COLS - 1);
  localparam logic [PAGE_W-1:0] LAST_DATA = PAGE_W'(DATA_PAGES - 1);
  localparam logic [PAGE_W-1:0] IND_PAGE  = PAGE_W'(DATA_PAGES);

  logic [PAGE_W-1:0] page_q;
  logic [COL_W-1:0]  col_q;
  logic              mirror_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q   <= '0;
      col_q    <= '0;
      mirror_q <= 1'b0;
    end else begin
      if (acc) begin
        if (col_q == LAST_COL) begin
          col_q <= '0;
          if (page_q == LAST_DATA)
            page_q <= '0;
          else if (page_q < LAST_DATA)
            page_q <= page_q + 1'b1;
        end else begin
          col_q <= col_q + 1'b1;
        end
      end
      if (page_ld && page_val <= IND_PAGE)
        page_q <= page_val;
      if (col_ld && col_val <= LAST_COL)
        col_q <= col_val;
      if (mirror_ld)
        mirror_q <= mirror_val;
    end
  end

  assign ram_addr  = ADDR_W'(page_q) * ADDR_W'(COLS) + ADDR_W'(col_q);
  assign ram_we    = acc & acc_wr;
  assign ram_wdata = host_wdata;
  assign cur_page  = page_q;
  assign cur_col   = col_q;
  assign cur_seg   = mirror_q ? (LAST_COL - col_q) : col_q;

endmodule

// File: rtl/disp_addr_gen_chk.sv
module disp_addr_gen_chk #(
  parameter int COLS = 102,
  parameter int DATA_PAGES = 8,
  localparam int COL_W = $clog2(COLS),
  localparam int PAGE_W = $clog2(DATA_PAGES + 1),
  localparam int ADDR_W = $clog2((DATA_PAGES + 1) * COLS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              page_ld,
  input logic [PAGE_W-1:0] page_val,
  input logic              col_ld,
  input logic [COL_W-1:0]  col_val,
  input logic              mirror_ld,
  input logic              mirror_val,
  input logic              acc,
  input logic              acc_wr,
  input logic [7:0]        host_wdata,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_we,
  input logic [7:0]        ram_wdata,
  input logic [PAGE_W-1:0] cur_page,
  input logic [COL_W-1:0]  cur_col,
  input logic [COL_W-1:0]  cur_seg
);

  logic no_ld;
  assign no_ld = !page_ld && !col_ld;

  p_page_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cur_page <= PAGE_W'(DATA_PAGES));

  p_col_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cur_col <= COL_W'(COLS - 1));

  p_bad_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
    page_ld && page_val > PAGE_W'(DATA_PAGES) && !acc |=> $stable(cur_page));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && no_ld && cur_col < COL_W'(COLS - 1)
    |=> cur_col == $past(cur_col) + 1'b1 && $stable(cur_page));

  p_wrap_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && no_ld && cur_col == COL_W'(COLS - 1) && cur_page == PAGE_W'(DATA_PAGES - 1)
    |=> cur_col == '0 && cur_page == '0);

  p_ind_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && no_ld && cur_col == COL_W'(COLS - 1) && cur_page == PAGE_W'(DATA_PAGES)
    |=> cur_col == '0 && cur_page == PAGE_W'(DATA_PAGES));

  p_read_no_we_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && acc_wr) |-> !ram_we);

endmodule

bind disp_addr_gen disp_addr_gen_chk #(.COLS(COLS), .DATA_PAGES(DATA_PAGES)) chk_i (.*);

// File: tb/disp_addr_gen_tb_top.sv
`timescale 1ns/1ps
module disp_addr_gen_tb_top;
  localparam int COLS = 102;
  localparam int NPG  = 9;
  localparam int WORDS = COLS * NPG;

  logic clk = 0, rst_n = 0;
  logic page_ld = 0, col_ld = 0, mirror_ld = 0, mirror_val = 0, acc = 0, acc_wr = 0;
  logic [3:0] page_val = 0;
  logic [6:0] col_val = 0;
  logic [7:0] host_wdata = 0;
  logic [9:0] ram_addr;
  logic ram_we;
  logic [7:0] ram_wdata;
  logic [3:0] cur_page;
  logic [6:0] cur_col, cur_seg;

  always #2.5 clk = ~clk;

  disp_addr_gen dut_i (.*);

  logic [7:0] ram [WORDS];
  logic [7:0] mdl [WORDS];
  always @(posedge clk) if (ram_we) ram[ram_addr] <= ram_wdata;

  int n_chk = 0, n_fail = 0;
  int e_page = 0, e_col = 0, e_mir = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_seg(int c, int m);
    return m ? (COLS - 1 - c) : c;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic op(input bit pl, input int pv, input bit cl, input int cv,
                    input bit ml, input bit mv, input bit a, input bit w, input logic [7:0] d);
    int np, nc, addr;
    page_ld = pl; page_val = 4'(pv); col_ld = cl; col_val = 7'(cv);
    mirror_ld = ml; mirror_val = mv; acc = a; acc_wr = w; host_wdata = d;
    #1;
    addr = e_page * COLS + e_col;
    chk("R9 seg", cur_seg, exp_seg(e_col, e_mir));
    if (a) begin
      chk("R8 addr", ram_addr, addr);
      chk("R8 we", ram_we, w);
      if (w) chk("R8 wdata", ram_wdata, d);
      else   chk("R8 read data", ram[ram_addr], mdl[addr]);
    end else chk("R8 idle we", ram_we, 0);
    if (a && w) mdl[addr] = d;
    np = e_page; nc = e_col;
    if (a) begin
      if (e_col == COLS - 1) begin
        nc = 0;
        if (e_page == 7) np = 0;
        else if (e_page < 7) np = e_page + 1;
      end else nc = e_col + 1;
    end
    if (pl && pv <= 8) np = pv;
    if (cl && cv <= COLS - 1) nc = cv;
    if (ml) e_mir = mv;
    e_page = np; e_col = nc;
    @(negedge clk);
    page_ld = 0; col_ld = 0; mirror_ld = 0; acc = 0;
    chk(pl || cl ? "R2/R3/R10 load" : "R4-R7 page", cur_page, e_page);
    chk(pl || cl ? "R2/R3/R10 load" : "R4-R7 col", cur_col, e_col);
  endtask

  initial begin
    #(5 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < WORDS; i++) begin ram[i] = 0; mdl[i] = 0; end
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 page", cur_page, 0);
    chk("R1 col", cur_col, 0);
    chk("R1 seg", cur_seg, 0);
    // R5: carry from page 6 into page 7
    op(1, 6, 1, 100, 0, 0, 0, 0, 0);
    op(0, 0, 0, 0, 0, 0, 1, 1, 8'hA1);
    op(0, 0, 0, 0, 0, 0, 1, 1, 8'hA2);
    chk("R5 page", cur_page, 7);
    // R6: last data address wraps to origin
    op(0, 0, 1, 101, 0, 0, 0, 0, 0);
    op(0, 0, 0, 0, 0, 0, 1, 1, 8'h5C);
    chk("R6 page", cur_page, 0);
    chk("R6 col", cur_col, 0);
    // R7: indicator page holds
    op(1, 8, 1, 101, 0, 0, 0, 0, 0);
    op(0, 0, 0, 0, 0, 0, 1, 1, 8'h01);
    chk("R7 page", cur_page, 8);
    op(0, 0, 0, 0, 0, 0, 1, 0, 0);
    // R2/R3: illegal loads ignored
    op(1, 12, 1, 110, 0, 0, 0, 0, 0);
    chk("R2 page kept", cur_page, 8);
    chk("R3 col kept", cur_col, 1);
    // R9: mirror extremes
    op(0, 0, 1, 0, 1, 1, 0, 0, 0);
    chk("R9 col0 reversed", cur_seg, 101);
    op(0, 0, 1, 101, 0, 0, 0, 0, 0);
    chk("R9 col101 reversed", cur_seg, 0);
    // R10: load together with access
    op(1, 3, 1, 50, 0, 0, 1, 1, 8'h77);
    // R8: read back written bytes
    op(1, 6, 1, 100, 0, 0, 0, 0, 0);
    op(0, 0, 0, 0, 0, 0, 1, 0, 0);
    op(0, 0, 0, 0, 0, 0, 1, 0, 0);
    // R1: reset keeps RAM contents
    rst_n = 0; @(negedge clk); rst_n = 1; e_page = 0; e_col = 0; e_mir = 0;
    #1; chk("R1 reset page", cur_page, 0);
    op(1, 6, 1, 100, 0, 0, 0, 0, 0);
    op(0, 0, 0, 0, 0, 0, 1, 0, 0);
    for (int i = 0; i < 4000; i++) begin
      int k;
      k = $urandom % 16;
      case (k)
        0: op(1, $urandom % 16, 0, 0, 0, 0, 0, 0, 0);
        1: op(0, 0, 1, $urandom % 128, 0, 0, 0, 0, 0);
        2: op(0, 0, 0, 0, 1, 1'($urandom), 0, 0, 0);
        3: op(1'($urandom), $urandom % 16, 1'($urandom), $urandom % 128, 0, 0, 1, 1'($urandom), 8'($urandom));
        4: op(1, 7, 1, 90 + $urandom % 12, 0, 0, 1, 1, 8'($urandom));
        default: op(0, 0, 0, 0, 0, 0, 1, 1'($urandom), 8'($urandom));
      endcase
    end
    finish_run();
  end
endmodule